// File: doc/BRIEF.md
# Multichannel Lower-Triangle Matrix Stream Buffer

This block sits in front of a matrix engine that serves many channels. Matrices arrive as a stream of beats, each beat carrying an 8-bit channel tag and an opaque 64-bit complex word. The real part is in bits [63:32] and the imaginary part is in bits [31:0]. A matrix of size N is sent as its lower triangle only, N*(N+1)/2 beats in column-major order: column 0 rows 0..N-1, then column 1 rows 1..N-1, and so on. Each burst is written into a storage slot owned by its channel. When the last beat lands, the matrix is handed to the read side.

Each channel owns two slots, so a second matrix can be accepted while the first one is still being read. The downstream datapath reads by (channel, row, column) with a one-cycle read latency. A request in the upper triangle is answered with the conjugate of the mirrored element.

The input checks its own framing. It flags a burst that stops early, a burst whose channel changes or is out of range, a burst that starts before the idle gap has elapsed, and a burst aimed at a channel whose two slots are both occupied. The idle gap is LATENCY − N*(N+1)/2 cycles. A faulty burst is discarded and leaves a sticky flag behind.

Top module: `matrix_stream_buffer`

## Requirements
- R1: After reset, `mat_ready`, `err_flags`, `rq_ready` and `rsp_valid` are all zero.
- R2: A burst is accepted when it meets four conditions: exactly E = N*(N+1)/2 consecutive valid beats, a constant in-range channel, at least GAP = LATENCY − E idle cycles before its first beat, and a free slot on that channel. An accepted burst makes the matrix available, and `mat_ready[ch]` rises in the cycle after the last beat.
- R3: Beat k of a burst is element (r, c) with r ≥ c, where k = c*N − c*(c−1)/2 + (r − c). A request for (ch, r, c) with r ≥ c that is accepted on a clock edge returns that beat on `rsp_data`, with `rsp_valid` high, right after that edge and for one cycle.
- R4: A request with r < c returns element (c, r) with bit 31 (the sign of the imaginary part) inverted.
- R5: `rq_ready` is high exactly when `rq_channel` < CHANNELS, row and column are below N, and that channel holds an available matrix. It does not depend on `rq_valid`. An accepted request with `rq_release` high frees the matrix being read.
- R6: Each channel holds up to two completed matrices. They are served in arrival order, and the second becomes readable after the first is released.
- R7: If valid drops before the E-th beat, `err_flags[0]` is set and the partial matrix is discarded.
- R8: If the channel changes inside a burst, or a burst starts on a channel ≥ CHANNELS, `err_flags[1]` is set and the burst is discarded.
- R9: If a burst starts after fewer than GAP idle cycles, `err_flags[2]` is set and the burst is discarded.
- R10: If a burst starts on a channel that already holds two matrices, `err_flags[3]` is set, the burst is discarded and the held matrices are unchanged.
- R11: Error flags stay set until reset.
- R12: Channels are independent: bursts for different channels may follow one another, and each channel's content and readiness are unaffected by the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_channel | input | 8 | Channel tag of the beat |
| in_data | input | 64 | Complex element: real [63:32], imaginary [31:0] |
| mat_ready | output | CHANNELS | Per channel: a complete matrix is available for reading |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request can be accepted |
| rq_channel | input | 8 | Channel to read |
| rq_row | input | clog2(N) | Row index |
| rq_col | input | clog2(N) | Column index |
| rq_release | input | 1 | Free the matrix once this request is accepted |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 64 | Read data |
| err_flags | output | 4 | Sticky: [0] short burst, [1] channel fault, [2] gap too short, [3] overrun |

## Verification
The bench builds the block with N=4, CHANNELS=16 and LATENCY=30. This gives 10-beat bursts and a 20-cycle minimum gap, so every framing fault, a full double-buffer overrun and a complete read of both triangles fit in a few hundred cycles. With 2-bit row and column indices every index is in range, so range faults are exercised through channel tags of 16 and above. Each request covers the mirrored upper-triangle path as well as the direct lower-triangle path.

// File: rtl/mstb_pkg.sv
`timescale 1ns/1ps
package mstb_pkg;
    localparam int CHAN_W = 8;
    localparam int WORD_W = 64;

    typedef struct packed {
        logic [31:0] re;
        logic [31:0] im;
    } cplx_t;

    typedef struct packed {
        logic overrun;
        logic gap;
        logic chan;
        logic short_burst;
    } err_t;

    function automatic int tri_count(int n);
        return n * (n + 1) / 2;
    endfunction

    function automatic int tri_index(int n, int r, int c);
        return c * n - (c * (c - 1)) / 2 + (r - c);
    endfunction

    function automatic cplx_t conj(cplx_t x);
        cplx_t y;
        y = x;
        y.im[31] = ~x.im[31];
        return y;
    endfunction
endpackage

// File: rtl/mstb_tri_walker.sv
`timescale 1ns/1ps
module mstb_tri_walker #(
    parameter int N  = 4,
    parameter int IW = 4,
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          abort,
    output logic [IW-1:0] idx,
    output logic [RW-1:0] row,
    output logic [RW-1:0] col,
    output logic          first,
    output logic          last
);
    localparam int E = mstb_pkg::tri_count(N);

    assign first = (idx == '0);
    assign last  = (idx == IW'(E - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            idx <= '0;
            row <= '0;
            col <= '0;
        end else if (step) begin
            if (last) begin
                idx <= '0;
                row <= '0;
                col <= '0;
            end else begin
                idx <= idx + 1'b1;
                if (row == RW'(N - 1)) begin
                    col <= col + 1'b1;
                    row <= col + 1'b1;
                end else begin
                    row <= row + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mstb_burst_guard.sv
`timescale 1ns/1ps
module mstb_burst_guard
    import mstb_pkg::*;
#(
    parameter int N        = 4,
    parameter int CHANNELS = 16,
    parameter int LATENCY  = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_channel,
    input  logic              first,
    input  logic              last,
    input  logic              start_blocked,
    output logic              we,
    output logic              commit,
    output logic              abort,
    output logic [CHAN_W-1:0] cur_ch,
    output err_t              err
);
    localparam int E   = tri_count(N);
    localparam int GAP = LATENCY - E;
    localparam int GW  = $clog2(GAP + 1);
    localparam logic [GW-1:0]     GAP_V  = GW'(GAP);
    localparam logic [CHAN_W:0]   CH_LIM = (CHAN_W + 1)'(CHANNELS);

    logic [GW-1:0]     gap_q;
    logic [CHAN_W-1:0] ch_q;
    logic              bad_q;
    logic start, mismatch, range_bad, gap_bad, over_bad, start_bad, beat_bad;

    assign start     = in_valid && first;
    assign abort     = !first && !in_valid;
    assign mismatch  = in_valid && !first && (in_channel != ch_q);
    assign range_bad = start && ({1'b0, in_channel} >= CH_LIM);
    assign gap_bad   = start && (gap_q < GAP_V);
    assign over_bad  = start && !range_bad && start_blocked;
    assign start_bad = range_bad || gap_bad || over_bad;
    assign beat_bad  = start ? start_bad : (bad_q || mismatch);
    assign we        = in_valid && !beat_bad;
    assign commit    = in_valid && last && !beat_bad;
    assign cur_ch    = start ? in_channel : ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_V;
            ch_q  <= '0;
            bad_q <= 1'b0;
            err   <= '0;
        end else begin
            if (in_valid)            gap_q <= '0;
            else if (gap_q < GAP_V)  gap_q <= gap_q + 1'b1;
            if (start) begin
                ch_q  <= in_channel;
                bad_q <= start_bad;
            end else if (mismatch) begin
                bad_q <= 1'b1;
            end
            if (abort)                  err.short_burst <= 1'b1;
            if (mismatch || range_bad)  err.chan        <= 1'b1;
            if (gap_bad)                err.gap         <= 1'b1;
            if (over_bad)               err.overrun     <= 1'b1;
        end
    end
endmodule

// File: rtl/mstb_ram.sv
`timescale 1ns/1ps
module mstb_ram #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 320,
    parameter int AW    = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/matrix_stream_buffer.sv
`timescale 1ns/1ps
module matrix_stream_buffer
    import mstb_pkg::*;
#(
    parameter int N        = 4,
    parameter int CHANNELS = 16,
    parameter int LATENCY  = 30
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [7:0]                     in_channel,
    input  logic [63:0]                    in_data,
    output logic [CHANNELS-1:0]            mat_ready,
    input  logic                           rq_valid,
    output logic                           rq_ready,
    input  logic [7:0]                     rq_channel,
    input  logic [((N>1)?$clog2(N):1)-1:0] rq_row,
    input  logic [((N>1)?$clog2(N):1)-1:0] rq_col,
    input  logic                           rq_release,
    output logic                           rsp_valid,
    output logic [63:0]                    rsp_data,
    output logic [3:0]                     err_flags
);
    localparam int E     = tri_count(N);
    localparam int IW    = (E > 1) ? $clog2(E) : 1;
    localparam int RW    = (N > 1) ? $clog2(N) : 1;
    localparam int CIW   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
    localparam int DEPTH = CHANNELS * 2 * E;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [CHAN_W:0] CH_LIM = (CHAN_W + 1)'(CHANNELS);
    localparam logic [RW:0]     N_LIM  = (RW + 1)'(N);

    logic [IW-1:0]     w_idx;
    logic [RW-1:0]     w_row, w_col;
    logic              w_first, w_last;
    logic              g_we, g_commit, g_abort;
    logic [CHAN_W-1:0] g_ch;
    err_t              g_err;

    logic [CHANNELS-1:0][1:0] full;
    logic [CHANNELS-1:0]      wr_bank, rd_bank;

    logic [CIW-1:0] in_ci, wch, rch;
    logic           start_blocked;
    logic [AW-1:0]  wr_addr, rd_addr;
    logic           swap, in_range, accept, mirror_q;
    logic [RW-1:0]  r_hi, r_lo;
    logic [63:0]    ram_q;

    assign in_ci         = in_channel[CIW-1:0];
    assign start_blocked = full[in_ci][wr_bank[in_ci]];

    mstb_tri_walker #(.N(N), .IW(IW), .RW(RW)) u_walk (
        .clk(clk), .rst(rst), .step(in_valid), .abort(g_abort),
        .idx(w_idx), .row(w_row), .col(w_col), .first(w_first), .last(w_last)
    );

    mstb_burst_guard #(.N(N), .CHANNELS(CHANNELS), .LATENCY(LATENCY)) u_guard (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_channel(in_channel),
        .first(w_first), .last(w_last), .start_blocked(start_blocked),
        .we(g_we), .commit(g_commit), .abort(g_abort), .cur_ch(g_ch), .err(g_err)
    );

    assign wch     = g_ch[CIW-1:0];
    assign wr_addr = AW'((int'(wch) * 2 + int'(wr_bank[wch])) * E + int'(w_idx));

    assign swap     = rq_row < rq_col;
    assign r_hi     = swap ? rq_col : rq_row;
    assign r_lo     = swap ? rq_row : rq_col;
    assign rch      = rq_channel[CIW-1:0];
    assign in_range = ({1'b0, rq_channel} < CH_LIM) && ({1'b0, rq_row} < N_LIM)
                      && ({1'b0, rq_col} < N_LIM);
    assign rq_ready = in_range && full[rch][rd_bank[rch]];
    assign accept   = rq_valid && rq_ready;
    assign rd_addr  = AW'((int'(rch) * 2 + int'(rd_bank[rch])) * E
                          + tri_index(N, int'(r_hi), int'(r_lo)));

    mstb_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(g_we), .waddr(wr_addr), .wdata(in_data),
        .re(accept), .raddr(rd_addr), .rdata(ram_q)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic set_hit, clr_hit;
        assign set_hit      = g_commit && (wch == CIW'(c));
        assign clr_hit      = accept && rq_release && (rch == CIW'(c));
        assign mat_ready[c] = full[c][rd_bank[c]];

        always_ff @(posedge clk) begin
            if (rst) begin
                full[c]    <= '0;
                wr_bank[c] <= 1'b0;
                rd_bank[c] <= 1'b0;
            end else begin
                if (set_hit) begin
                    full[c][wr_bank[c]] <= 1'b1;
                    wr_bank[c]          <= ~wr_bank[c];
                end
                if (clr_hit) begin
                    full[c][rd_bank[c]] <= 1'b0;
                    rd_bank[c]          <= ~rd_bank[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            mirror_q  <= 1'b0;
        end else begin
            rsp_valid <= accept;
            mirror_q  <= swap;
        end
    end

    assign rsp_data  = mirror_q ? conj(cplx_t'(ram_q)) : ram_q;
    assign err_flags = g_err;
endmodule

// File: rtl/mstb_checker.sv
`timescale 1ns/1ps
module mstb_checker #(
    parameter int N        = 4,
    parameter int CHANNELS = 16,
    parameter int RW       = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                rq_valid,
    input logic                rq_ready,
    input logic [7:0]          rq_channel,
    input logic                rsp_valid,
    input logic [CHANNELS-1:0] mat_ready,
    input logic [3:0]          err_flags,
    input logic [RW-1:0]       walk_row,
    input logic [RW-1:0]       walk_col,
    input logic                walk_first
);
    // R3: response follows an accepted request by exactly one cycle
    a_r3_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && rq_ready) |=> rsp_valid);
    a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(rq_valid && rq_ready) |=> !rsp_valid);
    // R3: beat walker stays inside the lower triangle
    a_r3_walk_lower: assert property (@(posedge clk) disable iff (rst)
        (walk_row >= walk_col) && (int'(walk_row) < N));
    // R2: a matrix only becomes ready after an input beat
    a_r2_ready_after_beat: assert property (@(posedge clk) disable iff (rst)
        ((mat_ready & ~$past(mat_ready)) != '0) |-> $past(in_valid));
    // R5: acceptance only for a channel with a ready matrix
    a_r5_ready_needs_matrix: assert property (@(posedge clk) disable iff (rst)
        rq_ready |-> mat_ready[rq_channel]);
    // R7: valid dropping mid-burst raises the short flag
    a_r7_short_flag: assert property (@(posedge clk) disable iff (rst)
        (!walk_first && !in_valid) |=> err_flags[0]);
    // R11: flags never clear outside reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flags != 4'h0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind matrix_stream_buffer mstb_checker #(.N(N), .CHANNELS(CHANNELS), .RW(RW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_channel(rq_channel), .rsp_valid(rsp_valid),
    .mat_ready(mat_ready), .err_flags(err_flags), .walk_row(w_row),
    .walk_col(w_col), .walk_first(w_first)
);

// File: tb/sim_matrix_stream_buffer.sv
`timescale 1ns/1ps
module sim_matrix_stream_buffer;
    localparam int N   = 4;
    localparam int CH  = 16;
    localparam int LAT = 30;
    localparam int E   = N * (N + 1) / 2;
    localparam int GAP = LAT - E;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_channel = '0;
    logic [63:0]   in_data = '0;
    logic [CH-1:0] mat_ready;
    logic          rq_valid = 1'b0, rq_ready, rq_release = 1'b0;
    logic [7:0]    rq_channel = '0;
    logic [1:0]    rq_row = '0, rq_col = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic [3:0]    err_flags;

    matrix_stream_buffer #(.N(N), .CHANNELS(CH), .LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_channel(in_channel),
        .in_data(in_data), .mat_ready(mat_ready), .rq_valid(rq_valid),
        .rq_ready(rq_ready), .rq_channel(rq_channel), .rq_row(rq_row),
        .rq_col(rq_col), .rq_release(rq_release), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .err_flags(err_flags)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, seq = 0;
    logic [63:0] sent [CH][E];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int tidx(int r, int c);
        return c * N - c * (c - 1) / 2 + (r - c);
    endfunction

    // Behavioural reference model
    int          m_idx, m_idle, m_bch;
    bit          m_bad, e_rsp_v;
    logic [63:0] m_cur [$];
    logic [63:0] m_q [CH][$];
    logic [3:0]  m_err;
    logic [63:0] e_rsp_d;

    always @(posedge clk) begin
        bit acc, sw;
        int rr, cc;
        if (rst) begin
            m_idx = 0; m_idle = GAP; m_bch = 0; m_bad = 0; m_err = '0;
            e_rsp_v = 0; e_rsp_d = '0; m_cur.delete();
            for (int c = 0; c < CH; c++) m_q[c].delete();
        end else begin
            acc = rq_valid && rq_channel < CH && m_q[rq_channel].size() >= E;
            e_rsp_v = acc;
            if (acc) begin
                sw = rq_row < rq_col;
                rr = sw ? int'(rq_col) : int'(rq_row);
                cc = sw ? int'(rq_row) : int'(rq_col);
                e_rsp_d = m_q[rq_channel][tidx(rr, cc)];
                if (sw) e_rsp_d[31] = ~e_rsp_d[31];
            end
            if (in_valid) begin
                if (m_idx == 0) begin
                    m_bad = 0; m_bch = int'(in_channel); m_cur.delete();
                    if (m_idle < GAP) begin m_err[2] = 1'b1; m_bad = 1; end
                    if (in_channel >= CH) begin m_err[1] = 1'b1; m_bad = 1; end
                    else if (m_q[in_channel].size() >= 2 * E) begin
                        m_err[3] = 1'b1; m_bad = 1;
                    end
                end else if (int'(in_channel) != m_bch) begin
                    m_err[1] = 1'b1; m_bad = 1;
                end
                m_cur.push_back(in_data);
                m_idx++;
                m_idle = 0;
                if (m_idx == E) begin
                    if (!m_bad) foreach (m_cur[k]) m_q[m_bch].push_back(m_cur[k]);
                    m_idx = 0;
                end
            end else begin
                if (m_idx != 0) begin m_err[0] = 1'b1; m_idx = 0; end
                if (m_idle < GAP) m_idle++;
            end
            if (acc && rq_release)
                for (int k = 0; k < E; k++) void'(m_q[rq_channel].pop_front());
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        logic [CH-1:0] e_rdy;
        logic          e_rq;
        #1;
        if (!rst) begin
            for (int c = 0; c < CH; c++) e_rdy[c] = m_q[c].size() >= E;
            e_rq = rq_channel < CH && m_q[rq_channel].size() >= E;
            chk("R2 mat_ready", 64'(mat_ready), 64'(e_rdy));
            chk("R5 rq_ready", 64'(rq_ready), 64'(e_rq));
            chk("R11 err_flags", 64'(err_flags), 64'(m_err));
            chk("R3 rsp_valid", 64'(rsp_valid), 64'(e_rsp_v));
            if (e_rsp_v) chk("R3 rsp_data", rsp_data, e_rsp_d);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic burst(int ch, int gap, int nb, int chg_at, int chg_ch);
        repeat (gap) begin
            @(negedge clk);
            in_valid = 1'b0; rq_valid = 1'b0;
        end
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            seq++;
            in_valid   = 1'b1;
            in_channel = 8'((k >= chg_at) ? chg_ch : ch);
            in_data    = {8'(ch), 8'(k), 16'(seq), 32'(seq * 32'h9E37_79B9)};
            if (ch < CH && k < E) sent[ch][k] = in_data;
        end
    endtask

    task automatic quiet(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; rq_valid = 1'b0; rq_release = 1'b0;
        end
    endtask

    task automatic rd(int ch, int r, int c, bit rel);
        @(negedge clk);
        in_valid = 1'b0;
        rq_valid = 1'b1; rq_channel = 8'(ch);
        rq_row = 2'(r); rq_col = 2'(c); rq_release = rel;
    endtask

    task automatic read_all(int ch, bit rel);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                rd(ch, r, c, rel && r == N - 1 && c == N - 1);
        quiet(1);
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 mat_ready", 64'(mat_ready), 64'h0);
        chk("R1 err_flags", 64'(err_flags), 64'h0);
        chk("R1 rq_ready", 64'(rq_ready), 64'h0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);

        // R2 R12: two channels back to back
        burst(3, GAP, E, E + 1, 0);
        burst(5, GAP, E, E + 1, 0);
        settle();
        chk("R2 ch3 ready", 64'(mat_ready[3]), 64'h1);
        chk("R12 ch5 ready", 64'(mat_ready[5]), 64'h1);

        // R3 R4: direct and mirrored reads
        rd(3, 2, 1, 1'b0);
        settle();
        chk("R3 element (2,1)", rsp_data, sent[3][tidx(2, 1)]);
        rd(3, 1, 2, 1'b0);
        settle();
        chk("R4 mirrored (1,2)", rsp_data, sent[3][tidx(2, 1)] ^ 64'h8000_0000);
        read_all(3, 1'b1);
        settle();
        chk("R5 released ch3", 64'(mat_ready[3]), 64'h0);
        chk("R12 ch5 kept", 64'(mat_ready[5]), 64'h1);
        read_all(5, 1'b0);

        // R6 R10: double buffer, then overrun
        burst(7, GAP, E, E + 1, 0);
        burst(7, GAP, E, E + 1, 0);
        burst(7, GAP, E, E + 1, 0);
        settle();
        chk("R10 overrun flag", 64'(err_flags[3]), 64'h1);
        read_all(7, 1'b1);
        settle();
        chk("R6 second matrix ready", 64'(mat_ready[7]), 64'h1);
        read_all(7, 1'b1);
        settle();
        chk("R6 both drained", 64'(mat_ready[7]), 64'h0);

        // R7: short burst
        burst(1, GAP, 5, E + 1, 0);
        quiet(1);
        settle();
        chk("R7 short flag", 64'(err_flags[0]), 64'h1);
        chk("R7 discarded", 64'(mat_ready[1]), 64'h0);

        // R8: channel change and out-of-range channel
        burst(2, GAP, E, 4, 9);
        quiet(1);
        settle();
        chk("R8 channel flag", 64'(err_flags[1]), 64'h1);
        chk("R8 discarded", 64'(mat_ready[2]), 64'h0);
        burst(20, GAP, E, E + 1, 0);
        quiet(1);

        // R9: gap violation
        burst(4, GAP, E, E + 1, 0);
        burst(6, 5, E, E + 1, 0);
        quiet(1);
        settle();
        chk("R9 gap flag", 64'(err_flags[2]), 64'h1);
        chk("R9 discarded", 64'(mat_ready[6]), 64'h0);
        chk("R9 previous kept", 64'(mat_ready[4]), 64'h1);

        // R11: flags persist across a good burst
        burst(8, GAP, E, E + 1, 0);
        quiet(1);
        settle();
        chk("R11 all flags held", 64'(err_flags), 64'hF);
        chk("R2 ch8 ready", 64'(mat_ready[8]), 64'h1);

        // R5: requests that cannot be accepted
        rd(1, 0, 0, 1'b0);
        settle();
        chk("R5 empty channel", 64'(rq_ready), 64'h0);
        rd(20, 0, 0, 1'b0);
        settle();
        chk("R5 channel out of range", 64'(rq_ready), 64'h0);
        read_all(4, 1'b1);
        read_all(8, 1'b0);
        quiet(4);
        finish_run();
    end
endmodule